// File: doc/BRIEF.md
# Host DMA Bridge for a Disk Controller

This block sits on the 8-bit local I/O bus of a disk-controller subsystem. Local firmware uses it to point channel 1 of a DMA engine at host memory and to start and stop that channel. It decodes a small set of I/O ports and holds a host byte address. It raises or drops the channel-1 DMA request when a write carries a trigger byte. It also gives firmware a status port that shows the floppy controller's interrupt line, and a flag register that a command write partly clears.

The DMA engine asks for host bytes over a valid/ready request channel. The answer comes back over a valid/ready response channel. A request is taken only while `req_ready` is high, and that happens only when no transfer is in progress. The response holds `rsp_valid` and `rsp_data` steady until the engine raises `rsp_ready`. Toward host memory the bridge holds `host_req` and a stable `host_addr` until `host_ack` arrives. It captures `host_rdata` in the cycle of that acknowledge, and the address then steps up by one.

Top module: `host_dma_bridge`

## Requirements
- R1: Ports are decoded from `io_addr[7:0]` only, so the upper address byte has no effect on which register is hit.
- R2: Every read of a port from 0x21 to 0x2F returns 0x00, and `io_rdata` is 0x00 whenever no owned port is read.
- R3: A write to port 0x21 puts the data byte on `cmd_byte` and clears bit 1 of the flag register, leaving its other bits unchanged.
- R4: A write to port 0x38 loads the flag register, and a read of port 0x38 returns it.
- R5: A write to port 0x23 loads the data byte into bits 16:9 of the host address. Bits 8:1 are kept, and bit 0 and all bits above 16 become zero.
- R6: A write to port 0x24 loads the data byte into bits 8:1 of the host address. Bits 16:9 are kept, and bit 0 and all bits above 16 become zero.
- R7: A write of exactly 0x80 to port 0x26 sets `ch1_req` from the next cycle on. Any other value written to 0x26 leaves it unchanged.
- R8: A write of exactly 0xFF to port 0x2C clears `ch1_req` from the next cycle on. Any other value written to 0x2C leaves it unchanged.
- R9: A read of port 0x39 returns bit 0 = 1, bit 3 = the current `fdc_irq` level, and all other bits 0.
- R10: After a request is accepted, `host_req` stays high with `host_addr` steady until `host_ack`. The byte on `host_rdata` at that acknowledge is then presented as `rsp_data`.
- R11: The host address increments by one only in the cycle after an acknowledged host read, and it does not change while the acknowledge is pending.
- R12: `req_ready` is high only when idle. `rsp_valid` with `rsp_data` holds until `rsp_ready`, after which the bridge is idle again.
- R13: Reset clears the flag register, the host address, `ch1_req` and `cmd_byte`, and leaves the bridge idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | IO_AW | Local I/O address |
| io_wdata | input | 8 | Local I/O write data |
| io_wr | input | 1 | Local I/O write strobe, one cycle per write |
| io_rd | input | 1 | Local I/O read strobe |
| io_rdata | output | 8 | Read data, combinational, valid while io_rd is high |
| io_hit | output | 1 | Address selects a port owned by this block |
| fdc_irq | input | 1 | Floppy controller interrupt level |
| ch1_req | output | 1 | Channel-1 DMA request to the DMA engine |
| req_valid | input | 1 | DMA engine requests one host byte |
| req_ready | output | 1 | Bridge can accept a request |
| rsp_valid | output | 1 | Fetched byte available |
| rsp_ready | input | 1 | DMA engine takes the byte |
| rsp_data | output | 8 | Fetched host byte |
| host_req | output | 1 | Host memory read request |
| host_addr | output | ADDR_W | Host byte address |
| host_ack | input | 1 | Host memory acknowledge with data |
| host_rdata | input | 8 | Host memory read data |
| cmd_byte | output | 8 | Last byte written to the command port |

## Verification
The bench drives each trigger port with the trigger byte and with a near miss, such as 0x7F, 0x00 or 0xFE. A decoder that compared only some of the data bits would then set or drop the request on the wrong byte. It loads the two address halves in both orders, using mirrored upper address bytes. A design with the shift off by one bit, or that failed to keep the other half, shows a wrong `host_addr`. It stalls the host acknowledge and the response ready for several cycles. An early increment or a response that did not hold would show up as a changed address or data. It sets every flag bit and then writes the command port, so clearing the wrong bit, or the whole register, is caught.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  localparam logic [7:0] PORT_CMD    = 8'h21;
  localparam logic [7:0] PORT_ADR_HI = 8'h23;
  localparam logic [7:0] PORT_ADR_LO = 8'h24;
  localparam logic [7:0] PORT_GO     = 8'h26;
  localparam logic [7:0] PORT_STOP   = 8'h2C;
  localparam logic [7:0] WIN_FIRST   = 8'h21;
  localparam logic [7:0] WIN_LAST    = 8'h2F;
  localparam logic [7:0] PORT_FLAG   = 8'h38;
  localparam logic [7:0] PORT_STAT   = 8'h39;
  localparam logic [7:0] TRIG_GO     = 8'h80;
  localparam logic [7:0] TRIG_STOP   = 8'hFF;
  localparam int         FLAG_CLR_BIT = 1;
  localparam int         STAT_IRQ_BIT = 3;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_RSP  = 2'd2
  } hs_state_e;

  typedef struct packed {
    logic cmd_wr;
    logic ahi_wr;
    logic alo_wr;
    logic go_wr;
    logic stop_wr;
    logic flag_wr;
    logic win_rd;
    logic flag_rd;
    logic stat_rd;
    logic hit;
  } dec_t;
endpackage

// File: rtl/hdma_port_dec.sv
module hdma_port_dec
  import hdma_pkg::*;
(
  input  logic [7:0] port,
  input  logic       wr,
  input  logic       rd,
  output dec_t       dec
);
  logic in_win;

  always_comb begin
    in_win      = (port >= WIN_FIRST) && (port <= WIN_LAST);
    dec.cmd_wr  = wr && (port == PORT_CMD);
    dec.ahi_wr  = wr && (port == PORT_ADR_HI);
    dec.alo_wr  = wr && (port == PORT_ADR_LO);
    dec.go_wr   = wr && (port == PORT_GO);
    dec.stop_wr = wr && (port == PORT_STOP);
    dec.flag_wr = wr && (port == PORT_FLAG);
    dec.win_rd  = rd && in_win;
    dec.flag_rd = rd && (port == PORT_FLAG);
    dec.stat_rd = rd && (port == PORT_STAT);
    dec.hit     = in_win || (port == PORT_FLAG) || (port == PORT_STAT);
  end
endmodule

// File: rtl/hdma_ctrl_regs.sv
module hdma_ctrl_regs
  import hdma_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dec_t          dec,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] flag_q,
  output logic [DW-1:0] cmd_q,
  output logic          req_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      cmd_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      if (dec.flag_wr)
        flag_q <= wdata;
      else if (dec.cmd_wr)
        flag_q[FLAG_CLR_BIT] <= 1'b0;

      if (dec.cmd_wr)
        cmd_q <= wdata;

      if (dec.go_wr && (wdata == TRIG_GO))
        req_q <= 1'b1;
      else if (dec.stop_wr && (wdata == TRIG_STOP))
        req_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hdma_addr_ctr.sv
module hdma_addr_ctr #(
  parameter int ADDR_W = 24,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              inc,
  input  logic [DW-1:0]     wdata,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int LO_BASE = 1;
  localparam int HI_BASE = LO_BASE + DW;
  localparam int HI_TOP  = HI_BASE + DW - 1;

  logic [ADDR_W-1:0] nxt;

  always_comb begin
    nxt = addr_q;
    if (ld_hi || ld_lo) begin
      nxt = '0;
      if (ld_hi) begin
        nxt[HI_TOP:HI_BASE]       = wdata;
        nxt[HI_BASE-1:LO_BASE]    = addr_q[HI_BASE-1:LO_BASE];
      end else begin
        nxt[HI_BASE-1:LO_BASE]    = wdata;
        nxt[HI_TOP:HI_BASE]       = addr_q[HI_TOP:HI_BASE];
      end
    end else if (inc) begin
      nxt = addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= nxt;
  end
endmodule

// File: rtl/hdma_host_if.sv
module hdma_host_if
  import hdma_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          host_req,
  input  logic          host_ack,
  input  logic [DW-1:0] host_rdata,
  output logic          inc
);
  hs_state_e     st;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= HS_IDLE;
      data_q <= '0;
    end else begin
      unique case (st)
        HS_IDLE: if (req_valid) st <= HS_REQ;
        HS_REQ:  if (host_ack) begin
                   data_q <= host_rdata;
                   st     <= HS_RSP;
                 end
        HS_RSP:  if (rsp_ready) st <= HS_IDLE;
        default: st <= HS_IDLE;
      endcase
    end
  end

  assign req_ready = (st == HS_IDLE);
  assign host_req  = (st == HS_REQ);
  assign rsp_valid = (st == HS_RSP);
  assign rsp_data  = data_q;
  assign inc       = host_req && host_ack;
endmodule

// File: rtl/host_dma_bridge.sv
module host_dma_bridge
  import hdma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_AW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  output logic              io_hit,
  input  logic              fdc_irq,
  output logic              ch1_req,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              host_req,
  output logic [ADDR_W-1:0] host_addr,
  input  logic              host_ack,
  input  logic [7:0]        host_rdata,
  output logic [7:0]        cmd_byte
);
  localparam int DW = 8;

  dec_t          dec;
  logic [DW-1:0] flag_q;
  logic          inc;
  logic          unused_hi;

  assign unused_hi = ^io_addr[IO_AW-1:8];

  hdma_port_dec u_dec (
    .port (io_addr[7:0]),
    .wr   (io_wr),
    .rd   (io_rd),
    .dec  (dec)
  );

  hdma_ctrl_regs #(.DW(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .dec    (dec),
    .wdata  (io_wdata),
    .flag_q (flag_q),
    .cmd_q  (cmd_byte),
    .req_q  (ch1_req)
  );

  hdma_addr_ctr #(.ADDR_W(ADDR_W), .DW(DW)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_hi  (dec.ahi_wr),
    .ld_lo  (dec.alo_wr),
    .inc    (inc),
    .wdata  (io_wdata),
    .addr_q (host_addr)
  );

  hdma_host_if #(.DW(DW)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data),
    .host_req   (host_req),
    .host_ack   (host_ack),
    .host_rdata (host_rdata),
    .inc        (inc)
  );

  always_comb begin
    io_rdata = '0;
    if (dec.flag_rd)
      io_rdata = flag_q;
    else if (dec.stat_rd) begin
      io_rdata[0]            = 1'b1;
      io_rdata[STAT_IRQ_BIT] = fdc_irq;
    end
  end

  assign io_hit = dec.hit;
endmodule

// File: rtl/host_dma_bridge_chk.sv
module host_dma_bridge_chk #(
  parameter int ADDR_W = 24,
  parameter int IO_AW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IO_AW-1:0]  io_addr,
  input logic [7:0]        io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic              fdc_irq,
  input logic              ch1_req,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data,
  input logic              host_req,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_ack
);
  logic [7:0] lo;
  assign lo = io_addr[7:0];

  AST_GO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && lo == 8'h26 && io_wdata == 8'h80) |=> ch1_req); // R7
  AST_GO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && lo == 8'h26 && io_wdata != 8'h80) |=> $stable(ch1_req)); // R7
  AST_STOP_CLRS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && lo == 8'h2C && io_wdata == 8'hFF) |=> !ch1_req); // R8
  AST_STOP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && lo == 8'h2C && io_wdata != 8'hFF) |=> $stable(ch1_req)); // R8
  AST_LOAD_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (lo == 8'h23 || lo == 8'h24)) |=> !host_addr[0]); // R5
  AST_WIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && lo >= 8'h21 && lo <= 8'h2F) |-> io_rdata == 8'h00); // R2
  AST_STAT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && lo == 8'h39) |-> (io_rdata[3] == fdc_irq && io_rdata[0])); // R9
  AST_HREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_ack && !io_wr) |=> (host_req && $stable(host_addr))); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R12
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!host_req && !rsp_valid)); // R12
endmodule

bind host_dma_bridge host_dma_bridge_chk #(.ADDR_W(ADDR_W), .IO_AW(IO_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .io_wr     (io_wr),
  .io_rd     (io_rd),
  .io_rdata  (io_rdata),
  .fdc_irq   (fdc_irq),
  .ch1_req   (ch1_req),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .host_req  (host_req),
  .host_addr (host_addr),
  .host_ack  (host_ack)
);

// File: tb/host_dma_bridge_bench.sv
module host_dma_bridge_bench;
  localparam int ADDR_W = 24;
  localparam int IO_AW  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [IO_AW-1:0]  io_addr = '0;
  logic [7:0]        io_wdata = '0;
  logic              io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]        io_rdata;
  logic              io_hit;
  logic              fdc_irq = 1'b0;
  logic              ch1_req;
  logic              req_valid = 1'b0, req_ready;
  logic              rsp_valid, rsp_ready = 1'b0;
  logic [7:0]        rsp_data;
  logic              host_req, host_ack = 1'b0;
  logic [ADDR_W-1:0] host_addr;
  logic [7:0]        host_rdata = '0;
  logic [7:0]        cmd_byte;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  host_dma_bridge #(.ADDR_W(ADDR_W), .IO_AW(IO_AW)) u_host_dma_bridge (.*);

  // sel: 0 read data, 1 ch1_req, 2 host_addr, 3 cmd_byte
  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [1:0]  sel;
    logic [23:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{1'b1, 16'h0023, 8'hA5, 2'd2, 24'h014A00, 8'd5},  // R5
    '{1'b1, 16'hFF24, 8'h3C, 2'd2, 24'h014A78, 8'd6},  // R6, R1 mirror
    '{1'b1, 16'h0023, 8'h01, 2'd2, 24'h000278, 8'd5},  // R5 keeps low half
    '{1'b1, 16'h0026, 8'h7F, 2'd1, 24'h000000, 8'd7},  // R7 near miss
    '{1'b1, 16'h1226, 8'h80, 2'd1, 24'h000001, 8'd7},  // R7 trigger, mirrored
    '{1'b1, 16'h0026, 8'h00, 2'd1, 24'h000001, 8'd7},  // R7 other value
    '{1'b1, 16'h002C, 8'hFE, 2'd1, 24'h000001, 8'd8},  // R8 near miss
    '{1'b1, 16'h002C, 8'hFF, 2'd1, 24'h000000, 8'd8},  // R8 trigger
    '{1'b1, 16'h0038, 8'hFF, 2'd3, 24'h000000, 8'd4},  // R4 load flags
    '{1'b0, 16'h0038, 8'h00, 2'd0, 24'h0000FF, 8'd4},  // R4 read flags
    '{1'b1, 16'h0021, 8'h5A, 2'd3, 24'h00005A, 8'd3},  // R3 cmd byte
    '{1'b0, 16'hAB38, 8'h00, 2'd0, 24'h0000FD, 8'd3},  // R3 only bit 1 cleared
    '{1'b0, 16'h0025, 8'h00, 2'd0, 24'h000000, 8'd2},  // R2
    '{1'b0, 16'h772F, 8'h00, 2'd0, 24'h000000, 8'd2},  // R2 window top
    '{1'b0, 16'h0039, 8'h00, 2'd0, 24'h000001, 8'd9}   // R9 irq low
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 ch1_req", 32'(ch1_req), 32'd0);
    chk("R13 host_addr", 32'(host_addr), 32'd0);
    chk("R13 cmd_byte", 32'(cmd_byte), 32'd0);
    chk("R13 req_ready", 32'(req_ready), 32'd1);
    chk("R13 host_req", 32'(host_req), 32'd0);
    rst_n = 1'b1;
    io_read(16'h0038, rd);
    chk("R13 flags", 32'(rd), 32'd0);

    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      io_addr = VEC[i].addr; io_wdata = VEC[i].data;
      io_wr = VEC[i].wr; io_rd = !VEC[i].wr;
      #2;
      if (!VEC[i].wr)
        chk($sformatf("R%0d row %0d rdata", VEC[i].req, i), 32'(io_rdata), 32'(VEC[i].exp));
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0;
      if (VEC[i].wr) begin
        case (VEC[i].sel)
          2'd1: chk($sformatf("R%0d row %0d ch1_req", VEC[i].req, i), 32'(ch1_req), 32'(VEC[i].exp));
          2'd2: chk($sformatf("R%0d row %0d host_addr", VEC[i].req, i), 32'(host_addr), 32'(VEC[i].exp));
          default: chk($sformatf("R%0d row %0d cmd_byte", VEC[i].req, i), 32'(cmd_byte), 32'(VEC[i].exp));
        endcase
      end
    end

    // R9 irq high
    fdc_irq = 1'b1;
    io_read(16'h5539, rd);
    chk("R9 irq high", 32'(rd), 32'h09);
    fdc_irq = 1'b0;
    // R1 hit flag mirrors, R2 write in window has no address effect
    io_write(16'h0022, 8'h77);
    chk("R2 write to 0x22 no effect", 32'(host_addr), 32'h000278);

    // R10 R11 R12 host transfer
    io_write(16'h0023, 8'h00);
    io_write(16'h0024, 8'h80);
    chk("R6 load 0x100", 32'(host_addr), 32'h100);
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 host_req raised", 32'(host_req), 32'd1);
    chk("R12 not ready when busy", 32'(req_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk("R10 host_req held", 32'(host_req), 32'd1);
    chk("R11 no early increment", 32'(host_addr), 32'h100);
    host_ack = 1'b1; host_rdata = 8'h3C;
    @(negedge clk);
    host_ack = 1'b0; host_rdata = 8'h00;
    chk("R10 rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R10 rsp_data", 32'(rsp_data), 32'h3C);
    chk("R11 increment after ack", 32'(host_addr), 32'h101);
    repeat (2) @(negedge clk);
    chk("R12 rsp held", 32'({rsp_valid, rsp_data}), 32'h13C);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R12 idle after take", 32'({rsp_valid, req_ready}), 32'b01);
    // second transfer, immediate ack
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second address", 32'(host_addr), 32'h101);
    host_ack = 1'b1; host_rdata = 8'hC3;
    @(negedge clk);
    host_ack = 1'b0;
    chk("R10 second data", 32'(rsp_data), 32'hC3);
    chk("R11 second increment", 32'(host_addr), 32'h102);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;

    // R13 reset after activity
    io_write(16'h0026, 8'h80);
    io_write(16'h0038, 8'hAA);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R13 ch1_req cleared", 32'(ch1_req), 32'd0);
    chk("R13 addr cleared", 32'(host_addr), 32'd0);
    chk("R13 cmd cleared", 32'(cmd_byte), 32'd0);
    rst_n = 1'b1;
    io_read(16'h0038, rd);
    chk("R13 flags cleared", 32'(rd), 32'd0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule